// File: doc/BRIEF.md
# Half-Precision to Unsigned Integer Converter

This block takes one IEEE 754 binary16 value and returns it as a 32-bit unsigned integer. It is purely combinational. It handles every class of input: signed zeros, subnormals, normals, infinities and NaNs. Any fractional part is resolved by one of four rounding modes, which the caller selects on a 2-bit input for each conversion.

Two status flags come with the result. The invalid flag is raised when the value cannot be expressed as an unsigned integer. In that case the result is forced to the all-ones indefinite value. The inexact flag reports that a nonzero fraction was discarded on a valid conversion.

A negative input is legal only when its rounded magnitude is zero. For example, -0.4 rounded to nearest gives 0 and raises inexact only. The block is meant to be one lane of a packed conversion unit. The surrounding datapath replicates it and applies any per-lane write mask outside.

Top module: `half_to_uint_conv`

## Requirements
- R1: Positive and negative zero (0x0000, 0x8000) give 0 with both flags clear, in every rounding mode.
- R2: A positive input whose value is a whole number gives exactly that integer with both flags clear, in every mode.
- R3: Mode 2'b00 rounds to nearest, with ties going to the even integer: 2.5 gives 2, 3.5 gives 4, 0.5 gives 0.
- R4: Mode 2'b01 rounds toward negative infinity: a positive fraction is dropped (1.5 gives 1), and a negative nonzero fraction rounds to magnitude 1 or more.
- R5: Mode 2'b10 rounds toward positive infinity: a positive nonzero fraction rounds up (1.5 gives 2, 2.5 gives 3).
- R6: Mode 2'b11 rounds toward zero: the fraction is dropped for either sign (3.5 gives 3, -0.5 gives 0).
- R7: The inexact flag is 1 exactly when nonzero fraction bits were discarded and invalid is 0.
- R8: An input with an all-ones exponent field (bits 14:10), that is NaN or infinity of either sign, gives 0xFFFFFFFF with invalid=1 and inexact=0.
- R9: A negative finite input whose rounded magnitude is nonzero gives 0xFFFFFFFF with invalid=1 and inexact=0. A negative input that rounds to magnitude 0 gives 0 with invalid=0.
- R10: A subnormal input (exponent field 0, nonzero fraction) gives 0 or 1, set by its sign and the rounding mode, and raises inexact unless it is invalid.
- R11: Positive finite inputs never raise invalid. The largest one, 0x7BFF (65504), gives 65504.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_in | input | 16 | binary16 operand: sign bit 15, exponent bits 14:10, fraction bits 9:0 |
| rnd_mode | input | 2 | rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| u_out | output | 32 | unsigned integer result, or 0xFFFFFFFF when invalid |
| flag_invalid | output | 1 | the value cannot be represented as an unsigned integer |
| flag_inexact | output | 1 | nonzero fraction bits were discarded on a valid result |

## Verification
The bench builds the block with its default parameters: a 5-bit exponent, a 10-bit fraction and a 32-bit output. With those values the input space is small enough to sweep in full. All 65536 encodings are applied in each of the four rounding modes, so every subnormal, every rounding tie and every negative near zero is checked against a reference model. That model works on an exact scaled integer. Hand-worked directed cases come first, to pin the named ties and boundaries to known values.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  // Decide whether the kept magnitude steps up by one, given the sign,
  // its least significant bit, the first dropped bit and the rest.
  function automatic logic magnitude_step(rmode_e mode, logic neg, logic lsb,
                                          logic rbit, logic sticky);
    logic lost;
    lost = rbit | sticky;
    unique case (mode)
      RM_NEAR_EVEN: return rbit & (sticky | lsb);
      RM_DOWN:      return neg & lost;
      RM_UP:        return ~neg & lost;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hcvt_align.sv
module hcvt_align #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] x_in,
  output logic                  neg,
  output logic                  special,
  output logic                  ovf,
  output logic [INT_W-1:0]      ip,
  output logic                  rbit,
  output logic                  sticky
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int WIDE_W = INT_W + SIG_W;

  logic [EXP_W-1:0]  efield;
  logic [SIG_W-1:0]  sig;
  logic [WIDE_W-1:0] wide;
  int                ee, ue, sh;

  assign neg     = x_in[EXP_W+FRAC_W];
  assign efield  = x_in[EXP_W+FRAC_W-1:FRAC_W];
  assign special = &efield;
  assign sig     = {efield != '0, x_in[FRAC_W-1:0]};

  always_comb begin
    ee     = (efield == '0) ? 1 : int'(efield);
    ue     = ee - BIAS;
    sh     = 0;
    wide   = '0;
    rbit   = 1'b0;
    sticky = 1'b0;
    ovf    = 1'b0;
    if (ue >= INT_W) begin
      ovf = 1'b1;
    end else if (ue >= FRAC_W) begin
      wide = WIDE_W'(sig) << (ue - FRAC_W);
      ovf  = |wide[WIDE_W-1:INT_W];
    end else begin
      sh = FRAC_W - ue;
      if (sh > SIG_W) begin
        sticky = |sig;
      end else begin
        wide   = WIDE_W'(sig >> sh);
        rbit   = sig[sh-1];
        sticky = |(sig & ((SIG_W'(1) << (sh - 1)) - SIG_W'(1)));
      end
    end
  end

  assign ip = wide[INT_W-1:0];

endmodule

// File: rtl/hcvt_round.sv
module hcvt_round
  import hcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  rmode_e           mode,
  input  logic             neg,
  input  logic [INT_W-1:0] ip,
  input  logic             rbit,
  input  logic             sticky,
  output logic             inc,
  output logic [INT_W:0]   mag
);
  assign inc = magnitude_step(mode, neg, ip[0], rbit, sticky);
  assign mag = {1'b0, ip} + {{INT_W{1'b0}}, inc};

  always_comb begin
    if (!$isunknown({mode, neg, ip, rbit, sticky})) begin
      // R7
      step_needs_loss_chk: assert (!inc || rbit || sticky)
        else $error("increment without discarded bits");
      // R6
      zero_mode_keeps_chk: assert (mode != RM_ZERO || mag == {1'b0, ip})
        else $error("toward-zero mode changed the magnitude");
    end
  end

endmodule

// File: rtl/half_to_uint_conv.sv
module half_to_uint_conv
  import hcvt_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] h_in,
  input  logic [1:0]            rnd_mode,
  output logic [INT_W-1:0]      u_out,
  output logic                  flag_invalid,
  output logic                  flag_inexact
);
  localparam int EMAX = (1 << (EXP_W - 1)) - 1;
  localparam bit POS_FITS = (INT_W >= EMAX + 1);

  logic             neg, special, ovf, rbit, sticky, inc;
  logic [INT_W-1:0] ip;
  logic [INT_W:0]   mag;
  logic             neg_nonzero, too_big, lost;

  hcvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) align_i (
    .x_in(h_in), .neg(neg), .special(special), .ovf(ovf),
    .ip(ip), .rbit(rbit), .sticky(sticky)
  );

  hcvt_round #(.INT_W(INT_W)) round_i (
    .mode(rmode_e'(rnd_mode)), .neg(neg), .ip(ip), .rbit(rbit),
    .sticky(sticky), .inc(inc), .mag(mag)
  );

  assign neg_nonzero  = neg & (mag != '0);
  assign too_big      = ovf | mag[INT_W];
  assign lost         = rbit | sticky;
  assign flag_invalid = special | too_big | neg_nonzero;
  assign flag_inexact = lost & ~flag_invalid;
  assign u_out        = flag_invalid ? '1 : mag[INT_W-1:0];

  always_comb begin
    if (!$isunknown({h_in, rnd_mode})) begin
      // R8
      special_invalid_chk: assert (!special || (flag_invalid && u_out == '1 && !flag_inexact))
        else $error("NaN/infinity not flagged");
      // R1
      zero_clean_chk: assert (h_in[EXP_W+FRAC_W-1:0] != '0 ||
                              (u_out == '0 && !flag_invalid && !flag_inexact))
        else $error("zero input did not give clean zero");
      // R11
      pos_never_invalid_chk: assert (!POS_FITS || neg || special || !flag_invalid)
        else $error("positive finite input raised invalid");
      // R9
      neg_result_zero_chk: assert (!neg || flag_invalid || u_out == '0)
        else $error("negative input produced nonzero valid result");
    end
  end

endmodule

// File: tb/half_to_uint_conv_tb.sv
module half_to_uint_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_in = '0;
  logic [1:0]  rnd_mode = '0;
  logic [31:0] u_out;
  logic        flag_invalid, flag_inexact;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 0;

  always #10 clk = ~clk;   // 50 MHz

  half_to_uint_conv dut_i (
    .h_in(h_in), .rnd_mode(rnd_mode), .u_out(u_out),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  // Exact model: the value times 2^24 is an integer for every finite input.
  function automatic void model(input logic [15:0] x, input int m,
                                output longint res, output bit inv,
                                output bit inx, output string tag);
    int     e, f, ee;
    bit     s, up;
    longint n, q, rem, sig, mag;
    s = x[15]; e = int'(x[14:10]); f = int'(x[9:0]);
    if (e == 31) begin
      res = 64'hFFFF_FFFF; inv = 1; inx = 0; tag = "R8"; return;
    end
    sig = (e == 0) ? longint'(f) : longint'(f + 1024);
    ee  = (e == 0) ? 1 : e;
    n   = sig << (ee - 1);
    q   = n >>> 24;
    rem = n % (64'sd1 << 24);
    case (m)
      0: up = (rem > (64'sd1 << 23)) || (rem == (64'sd1 << 23) && (q % 2) == 1);
      1: up = s && rem != 0;
      2: up = !s && rem != 0;
      default: up = 0;
    endcase
    mag = q + (up ? 1 : 0);
    if ((s && mag != 0) || mag > 64'hFFFF_FFFF) begin
      res = 64'hFFFF_FFFF; inv = 1; inx = 0;
    end else begin
      res = mag; inv = 0; inx = (rem != 0);
    end
    if (x[14:0] == 0)       tag = "R1";
    else if (e == 0)        tag = "R10";
    else if (s)             tag = "R9";
    else if (rem == 0)      tag = "R2";
    else if (m == 0)        tag = "R3";
    else if (m == 1)        tag = "R4";
    else if (m == 2)        tag = "R5";
    else                    tag = "R6";
  endfunction

  task automatic compare(input string tag, input longint er, input bit ei, input bit ex);
    checks++;
    if (longint'(u_out) != er || flag_invalid != ei || flag_inexact != ex) begin
      errors++;
      $display("FAIL %s in=%h mode=%0d actual=%h/inv%0b/inx%0b expected=%h/inv%0b/inx%0b",
               tag, h_in, rnd_mode, u_out, flag_invalid, flag_inexact,
               er[31:0], ei, ex);
    end
  endtask

  // Directed vector: drive, settle, compare against hand-worked values.
  task automatic dir(input string tag, input logic [15:0] x, input logic [1:0] m,
                     input longint er, input bit ei, input bit ex);
    h_in = x; rnd_mode = m;
    #6;
    compare(tag, er, ei, ex);
    #4;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint er;
    bit     ei, ex;
    string  tag;
    #5;
    compare("R1", 0, 0, 0);           // reset-time state with zero input
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    dir("R1",  16'h8000, 2'b01, 0, 0, 0);
    dir("R2",  16'h3C00, 2'b10, 1, 0, 0);
    dir("R3",  16'h4100, 2'b00, 2, 0, 1);   // 2.5 -> 2
    dir("R3",  16'h4300, 2'b00, 4, 0, 1);   // 3.5 -> 4
    dir("R3",  16'h3800, 2'b00, 0, 0, 1);   // 0.5 -> 0
    dir("R4",  16'h3E00, 2'b01, 1, 0, 1);   // 1.5 -> 1
    dir("R4",  16'hB800, 2'b01, 64'hFFFF_FFFF, 1, 0); // -0.5 down -> -1
    dir("R5",  16'h3E00, 2'b10, 2, 0, 1);
    dir("R5",  16'h4100, 2'b10, 3, 0, 1);
    dir("R6",  16'h4300, 2'b11, 3, 0, 1);
    dir("R6",  16'hB800, 2'b11, 0, 0, 1);
    dir("R7",  16'h4000, 2'b00, 2, 0, 0);
    dir("R8",  16'h7C00, 2'b11, 64'hFFFF_FFFF, 1, 0);
    dir("R8",  16'hFE00, 2'b00, 64'hFFFF_FFFF, 1, 0);
    dir("R9",  16'hBC00, 2'b11, 64'hFFFF_FFFF, 1, 0);
    dir("R9",  16'hB400, 2'b00, 0, 0, 1);   // -0.25 -> 0
    dir("R10", 16'h0001, 2'b10, 1, 0, 1);
    dir("R10", 16'h0001, 2'b00, 0, 0, 1);
    dir("R10", 16'h8001, 2'b01, 64'hFFFF_FFFF, 1, 0);
    dir("R11", 16'h7BFF, 2'b10, 65504, 0, 0);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 65536; c++) begin
        h_in = c[15:0]; rnd_mode = m[1:0];
        #6;
        model(h_in, m, er, ei, ex, tag);
        compare(tag, er, ei, ex);
        #4;
      end
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule